// File: doc/BRIEF.md
# SPI Flash Opcode Dispatcher

This block sits at the front of an SPI flash target. It looks at the first byte of each transaction, searches a programmable table of command slots for that byte, and sends the rest of the transaction to one of seven downstream datapaths. The datapaths handle status read, identification read, discovery-table read, array read, upload to a buffer, address-width change and write-latch control. It also latches the matched slot, so the chosen datapath can read the slot's settings for the rest of the transaction.

Routing depends on the device mode and on the busy flag. In flash mode, the three register-style reads are always answered locally. In passthrough mode, each one is answered locally only when its own intercept enable is set. When it is not, the block parks in a wait state and the host traffic passes through untouched. The commands that change device state (address width, write latch, upload) are not recognised while the device is busy. Once a decision is taken, the block holds it until reset. Reset is active low and is normally driven by chip-select going inactive.

The byte input is a valid/ready stream with one rule. `byte_ready_o` is high only while the block is waiting for an opcode and the mode is active. A byte offered while ready is low is not consumed and has no effect. The sender does not need to hold it, because later bytes of a transaction belong to the datapaths.

Top module: `opcode_dispatch`

## Requirements
- R1: After reset:
  - the state is idle;
  - `dp_sel_o`, `cmd_info_o`, `pair_flag_o`, `intercept_o` and `pipe2_o` are all zero;
  - `byte_ready_o` equals 1 exactly when the mode is active.
- R2: The mode is active only for `mode_i` = 1 (flash) or 2 (passthrough). Modes 0 and 3 are inactive.
  - A byte is taken only when `byte_valid_i` and `byte_ready_o` are both high. `byte_ready_o` is high only in idle with an active mode.
  - In an inactive mode, bytes are ignored and the block stays idle.
- R3: The table holds 24 slots of 12 bits. Slot i sits at `slot_cfg_i[12*i +: 12]`, with these fields:
  - bit 11: valid;
  - bit 10: upload;
  - bits 9:8: pipeline mode;
  - bits 7:0: opcode.

  Slot roles are set by index: 0-2 status read, 3 identification read, 4 discovery read, 5-10 array read, 11 enter 4-byte, 12 exit 4-byte, 13 write enable, 14 write disable, 15-23 general.

  A slot matches when it is valid and its opcode equals the byte. The lowest-index matching slot wins.
- R4: In flash mode, a winning status, identification or discovery slot selects `dp_sel_o` bit 0, 1 or 2 respectively.
- R5: In passthrough mode, those three slots route only when `icpt_en_i` bit 0, 1 or 2 (same order) is set.
  - When they route, the same bit of `intercept_o` is set.
  - Otherwise the block waits with `dp_sel_o` = 0.
  - `intercept_o` stays 0 in flash mode.
- R6: A winning array-read slot selects `dp_sel_o` bit 3.
- R7: Slots 11-14 do not match while `busy_i` is high, and the search goes on to higher slots.
  - When busy is low, slots 11 and 12 select bit 5, and slots 13 and 14 select bit 6.
  - `pair_flag_o` is 1 for slots 11 and 13, and 0 for every other outcome.
- R8: A winning slot with index 11 or higher, upload bit set and `busy_i` low selects `dp_sel_o` bit 4, ahead of its own role. A general slot without upload, or with busy high, waits.
- R9: On the decision cycle, `cmd_info_o` captures the winning slot, or zero when nothing matches. `pipe2_o` is 1 when the captured pipeline mode is 2 or 3.
- R10: `dp_sel_o` is one-hot in a datapath state and zero in idle and wait. The state is never unknown after reset.
- R11: After a decision, all outputs hold until reset, whatever bytes, busy or mode follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Received byte |
| byte_valid_i | input | 1 | Byte strobe |
| byte_ready_o | output | 1 | Block waits for an opcode |
| mode_i | input | 2 | 1 flash, 2 passthrough, others inactive |
| busy_i | input | 1 | Device busy flag |
| icpt_en_i | input | 3 | Passthrough intercept enables: status, identification, discovery |
| slot_cfg_i | input | 288 | Command slot table |
| cmd_info_o | output | 12 | Captured winning slot |
| dp_sel_o | output | 7 | One-hot datapath select |
| pair_flag_o | output | 1 | Enter/enable member of a pair was received |
| intercept_o | output | 3 | Passthrough intercept record |
| pipe2_o | output | 1 | Captured slot uses a two-stage read pipeline |

## Verification
A wrong decision appears at the ports on the first clock edge after the opcode strobe. It shows as a wrong `dp_sel_o` bit, a wrong captured slot, a wrong pair flag or a wrong intercept bit. A state that leaks or drifts afterwards shows as outputs changing when a second byte arrives, or `byte_ready_o` staying high. Random tables drawn from a small opcode pool force slot collisions. Busy, mode and enables are varied on every trial, so the priority and gating paths are reached many times each.

// File: rtl/opdisp_pkg.sv
package opdisp_pkg;
  localparam int OPC_W   = 8;
  localparam int ENTRY_W = OPC_W + 4;
  localparam int DP_W    = 7;

  localparam int DP_STATUS = 0;
  localparam int DP_IDENT  = 1;
  localparam int DP_DISC   = 2;
  localparam int DP_READ   = 3;
  localparam int DP_UPLOAD = 4;
  localparam int DP_ADDRW  = 5;
  localparam int DP_WLATCH = 6;

  typedef struct packed {
    logic             valid;
    logic             upload;
    logic [1:0]       pipe;
    logic [OPC_W-1:0] opcode;
  } slot_t;

  typedef enum logic [3:0] {
    S_IDLE, S_STATUS, S_IDENT, S_DISC, S_READ,
    S_UPLOAD, S_ADDRW, S_WLATCH, S_WAIT
  } state_e;

  localparam logic [1:0] M_FLASH = 2'd1;
  localparam logic [1:0] M_PASS  = 2'd2;

  localparam logic [1:0] P_TWO_HALF = 2'd2;
  localparam logic [1:0] P_TWO_FULL = 2'd3;
endpackage

// File: rtl/slot_matcher.sv
module slot_matcher
  import opdisp_pkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int GATE_LO   = 11,
  parameter int GATE_HI   = 14
) (
  input  logic [NUM_SLOTS*ENTRY_W-1:0] slot_cfg_i,
  input  logic [OPC_W-1:0]             byte_i,
  input  logic                         busy_i,
  output logic [NUM_SLOTS-1:0]         hit_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam bit GATED = (g >= GATE_LO) && (g <= GATE_HI);
    slot_t s;
    assign s = slot_t'(slot_cfg_i[g*ENTRY_W +: ENTRY_W]);
    if (GATED) begin : g_gated
      assign hit_o[g] = s.valid && (s.opcode == byte_i) && !busy_i;
    end else begin : g_free
      assign hit_o[g] = s.valid && (s.opcode == byte_i);
    end
  end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  logic [N-1:0] below;
  assign below = (N'(1) << idx_o) - N'(1);

  always_comb begin
    if (found_o) begin
      assert_pick_lowest_R3: assert (req_i[idx_o] && ((req_i & below) == '0))
        else $error("picked slot is not the lowest requester");
    end
  end
endmodule

// File: rtl/dispatch_fsm.sv
module dispatch_fsm
  import opdisp_pkg::*;
#(
  parameter int NUM_SLOTS  = 24,
  parameter int NUM_STATUS = 3,
  parameter int NUM_READ   = 6,
  parameter int IDX_W      = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             found_i,
  input  logic [IDX_W-1:0] idx_i,
  input  slot_t            pick_i,
  input  logic [1:0]       mode_i,
  input  logic             busy_i,
  input  logic [2:0]       icpt_en_i,
  output state_e           state_o,
  output slot_t            rec_o,
  output logic             pair_o,
  output logic [2:0]       icpt_o
);
  localparam int IDENT_IDX = NUM_STATUS;
  localparam int DISC_IDX  = NUM_STATUS + 1;
  localparam int READ_BASE = NUM_STATUS + 2;
  localparam int EN4B_IDX  = READ_BASE + NUM_READ;
  localparam int EX4B_IDX  = EN4B_IDX + 1;
  localparam int WREN_IDX  = EN4B_IDX + 2;
  localparam int WRDI_IDX  = EN4B_IDX + 3;

  state_e     state_q, state_d;
  slot_t      rec_q, rec_d;
  logic       pair_q, pair_d;
  logic [2:0] icpt_q, icpt_d;
  logic [1:0] cls;
  state_e     cls_state;
  int         pos;

  assign pos = int'(idx_i);

  always_comb begin
    if (pos < IDENT_IDX) begin
      cls = 2'd0; cls_state = S_STATUS;
    end else if (pos == IDENT_IDX) begin
      cls = 2'd1; cls_state = S_IDENT;
    end else begin
      cls = 2'd2; cls_state = S_DISC;
    end
  end

  always_comb begin
    state_d = state_q;
    rec_d   = rec_q;
    pair_d  = pair_q;
    icpt_d  = icpt_q;
    if (take_i) begin
      state_d = S_WAIT;
      rec_d   = '0;
      pair_d  = 1'b0;
      icpt_d  = '0;
      if (found_i) begin
        rec_d = pick_i;
        if (pos <= DISC_IDX) begin
          if (mode_i == M_FLASH) begin
            state_d = cls_state;
          end else if (icpt_en_i[cls]) begin
            state_d     = cls_state;
            icpt_d[cls] = 1'b1;
          end
        end else if (pos < EN4B_IDX) begin
          state_d = S_READ;
        end else if (pick_i.upload && !busy_i) begin
          state_d = S_UPLOAD;
        end else if (pos == EN4B_IDX || pos == EX4B_IDX) begin
          state_d = S_ADDRW;
          pair_d  = (pos == EN4B_IDX);
        end else if (pos == WREN_IDX || pos == WRDI_IDX) begin
          state_d = S_WLATCH;
          pair_d  = (pos == WREN_IDX);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rec_q   <= '0;
      pair_q  <= 1'b0;
      icpt_q  <= '0;
    end else begin
      state_q <= state_d;
      rec_q   <= rec_d;
      pair_q  <= pair_d;
      icpt_q  <= icpt_d;
    end
  end

  assign state_o = state_q;
  assign rec_o   = rec_q;
  assign pair_o  = pair_q;
  assign icpt_o  = icpt_q;

  assert_idle_without_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !take_i) |=> (state_q == S_IDLE));

  assert_hold_decision_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> ($stable(state_q) && $stable(rec_q) && $stable(icpt_q)));

  assert_busy_gates_state_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && busy_i) |=> !(state_q inside {S_ADDRW, S_WLATCH, S_UPLOAD}));

  assert_flash_no_intercept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && mode_i == M_FLASH) |=> (icpt_q == 3'b000));

  assert_intercept_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(icpt_q));
endmodule

// File: rtl/opcode_dispatch.sv
module opcode_dispatch
  import opdisp_pkg::*;
#(
  parameter int NUM_SLOTS  = 24,
  parameter int NUM_STATUS = 3,
  parameter int NUM_READ   = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [OPC_W-1:0]             byte_i,
  input  logic                         byte_valid_i,
  output logic                         byte_ready_o,
  input  logic [1:0]                   mode_i,
  input  logic                         busy_i,
  input  logic [2:0]                   icpt_en_i,
  input  logic [NUM_SLOTS*ENTRY_W-1:0] slot_cfg_i,
  output logic [ENTRY_W-1:0]           cmd_info_o,
  output logic [DP_W-1:0]              dp_sel_o,
  output logic                         pair_flag_o,
  output logic [2:0]                   intercept_o,
  output logic                         pipe2_o
);
  localparam int IDX_W    = $clog2(NUM_SLOTS);
  localparam int EN4B_IDX = NUM_STATUS + 2 + NUM_READ;
  localparam int WRDI_IDX = EN4B_IDX + 3;

  logic [NUM_SLOTS-1:0] hit;
  logic                 found;
  logic [IDX_W-1:0]     idx;
  logic                 active;
  logic                 take;
  slot_t                pick;
  slot_t                rec;
  state_e               state;

  slot_matcher #(
    .NUM_SLOTS (NUM_SLOTS),
    .GATE_LO   (EN4B_IDX),
    .GATE_HI   (WRDI_IDX)
  ) u_match (
    .slot_cfg_i (slot_cfg_i),
    .byte_i     (byte_i),
    .busy_i     (busy_i),
    .hit_o      (hit)
  );

  lowest_pick #(
    .N     (NUM_SLOTS),
    .IDX_W (IDX_W)
  ) u_pick (
    .req_i   (hit),
    .found_o (found),
    .idx_o   (idx)
  );

  assign pick   = slot_t'(slot_cfg_i[int'(idx)*ENTRY_W +: ENTRY_W]);
  assign active = (mode_i == M_FLASH) || (mode_i == M_PASS);
  assign byte_ready_o = (state == S_IDLE) && active;
  assign take   = byte_ready_o && byte_valid_i;

  dispatch_fsm #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_STATUS (NUM_STATUS),
    .NUM_READ   (NUM_READ),
    .IDX_W      (IDX_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .found_i   (found),
    .idx_i     (idx),
    .pick_i    (pick),
    .mode_i    (mode_i),
    .busy_i    (busy_i),
    .icpt_en_i (icpt_en_i),
    .state_o   (state),
    .rec_o     (rec),
    .pair_o    (pair_flag_o),
    .icpt_o    (intercept_o)
  );

  always_comb begin
    dp_sel_o = '0;
    case (state)
      S_STATUS: dp_sel_o[DP_STATUS] = 1'b1;
      S_IDENT:  dp_sel_o[DP_IDENT]  = 1'b1;
      S_DISC:   dp_sel_o[DP_DISC]   = 1'b1;
      S_READ:   dp_sel_o[DP_READ]   = 1'b1;
      S_UPLOAD: dp_sel_o[DP_UPLOAD] = 1'b1;
      S_ADDRW:  dp_sel_o[DP_ADDRW]  = 1'b1;
      S_WLATCH: dp_sel_o[DP_WLATCH] = 1'b1;
      default:  dp_sel_o = '0;
    endcase
  end

  assign cmd_info_o = rec;
  assign pipe2_o    = (rec.pipe == P_TWO_HALF) || (rec.pipe == P_TWO_FULL);

  assert_sel_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dp_sel_o));

  assert_state_known_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(state));

  assert_no_ready_after_decision_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !byte_ready_o);

  assert_inactive_stays_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !active && state == S_IDLE) |=> (dp_sel_o == '0 && cmd_info_o == '0));
endmodule

// File: tb/opcode_dispatch_tb.sv
module opcode_dispatch_tb;
  localparam int NS = 24;
  localparam int EW = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     byte_in = '0;
  logic           bvalid = 1'b0;
  logic           bready;
  logic [1:0]     mode = 2'd1;
  logic           busy = 1'b0;
  logic [2:0]     icpt_en = '0;
  logic [NS*EW-1:0] cfg;
  logic [EW-1:0]  cmd_info;
  logic [6:0]     dp_sel;
  logic           pair_flag;
  logic [2:0]     intercept;
  logic           pipe2;

  logic [EW-1:0] tbl [NS];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) cfg[i*EW +: EW] = tbl[i];
  end

  opcode_dispatch u_dut (
    .clk_i (clk), .rst_ni (rst_n), .byte_i (byte_in), .byte_valid_i (bvalid),
    .byte_ready_o (bready), .mode_i (mode), .busy_i (busy), .icpt_en_i (icpt_en),
    .slot_cfg_i (cfg), .cmd_info_o (cmd_info), .dp_sel_o (dp_sel),
    .pair_flag_o (pair_flag), .intercept_o (intercept), .pipe2_o (pipe2)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] b, input logic [1:0] md, input logic bz,
                                input logic [2:0] en, output logic [6:0] sel,
                                output logic [11:0] rec, output logic pr,
                                output logic [2:0] icp);
    int w;
    sel = '0; rec = '0; pr = 1'b0; icp = '0; w = -1;
    if (md != 2'd1 && md != 2'd2) return;
    for (int i = 0; i < NS; i++) begin
      if (w < 0 && tbl[i][11] && tbl[i][7:0] == b && !(i >= 11 && i <= 14 && bz)) w = i;
    end
    if (w < 0) return;
    rec = tbl[w];
    if (w <= 4) begin
      int k;
      k = (w < 3) ? 0 : w - 2;
      if (md == 2'd1) sel[k] = 1'b1;
      else if (en[k]) begin sel[k] = 1'b1; icp[k] = 1'b1; end
    end else if (w <= 10) sel[3] = 1'b1;
    else if (rec[10] && !bz) sel[4] = 1'b1;
    else if (w == 11 || w == 12) begin sel[5] = 1'b1; pr = (w == 11); end
    else if (w == 13 || w == 14) begin sel[6] = 1'b1; pr = (w == 13); end
  endfunction

  task automatic clear_table();
    for (int i = 0; i < NS; i++) tbl[i] = '0;
  endtask

  task automatic set_slot(input int i, input logic up, input logic [1:0] pp, input logic [7:0] op);
    tbl[i] = {1'b1, up, pp, op};
  endtask

  task automatic trial(input string tag, input logic [7:0] b, input logic [1:0] md,
                       input logic bz, input logic [2:0] en);
    logic [6:0] es; logic [11:0] er; logic ep; logic [2:0] ei;
    logic act;
    act = (md == 2'd1 || md == 2'd2);
    @(negedge clk); rst_n = 1'b0; bvalid = 1'b0;
    mode = md; busy = bz; icpt_en = en;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "sel", 32'(dp_sel), 0);
    check("R1", "cmd", 32'(cmd_info), 0);
    check("R1", "icpt/pair/pipe", {27'd0, intercept, pair_flag, pipe2}, 0);
    check("R1", "ready", 32'(bready), 32'(act));
    model(b, md, bz, en, es, er, ep, ei);
    byte_in = b; bvalid = 1'b1;
    @(negedge clk); bvalid = 1'b0;
    check({tag, " R10"}, "sel", 32'(dp_sel), 32'(es));
    check({tag, " R9"}, "cmd", 32'(cmd_info), 32'(er));
    check({tag, " R7"}, "pair", 32'(pair_flag), 32'(ep));
    check({tag, " R5"}, "icpt", 32'(intercept), 32'(ei));
    check({tag, " R9"}, "pipe2", 32'(pipe2), 32'(er[9:8] >= 2'd2));
    check({tag, " R2"}, "ready", 32'(bready), 0);
    // R11 a second byte with changed conditions must not move a decision
    byte_in = b ^ 8'h01; bvalid = 1'b1; busy = ~bz;
    @(negedge clk); bvalid = 1'b0;
    if (act) begin
      check("R11", "sel hold", 32'(dp_sel), 32'(es));
      check("R11", "cmd hold", 32'(cmd_info), 32'(er));
    end
  endtask

  initial begin
    clear_table();
    repeat (3) @(negedge clk);

    // directed table
    set_slot(0, 0, 0, 8'h05); set_slot(1, 0, 0, 8'h35); set_slot(2, 0, 0, 8'h15);
    set_slot(3, 0, 0, 8'h9F); set_slot(4, 0, 0, 8'h5A);
    set_slot(5, 0, 2'd2, 8'h03); set_slot(6, 0, 2'd1, 8'h0B); set_slot(7, 0, 2'd3, 8'h15);
    set_slot(11, 0, 0, 8'hB7); set_slot(12, 0, 0, 8'hE9);
    set_slot(13, 0, 0, 8'h06); set_slot(14, 0, 0, 8'h04);
    set_slot(15, 0, 0, 8'h06); set_slot(16, 1, 0, 8'h02); set_slot(17, 0, 0, 8'h77);

    trial("R4", 8'h35, 2'd1, 1'b0, 3'b000);
    trial("R4", 8'h9F, 2'd1, 1'b1, 3'b000);
    trial("R4", 8'h5A, 2'd1, 1'b0, 3'b000);
    trial("R5", 8'h9F, 2'd2, 1'b0, 3'b101);
    trial("R5", 8'h9F, 2'd2, 1'b0, 3'b010);
    trial("R5", 8'h05, 2'd2, 1'b1, 3'b001);
    trial("R3", 8'h15, 2'd1, 1'b0, 3'b000);
    trial("R6", 8'h03, 2'd2, 1'b1, 3'b000);
    trial("R9", 8'h0B, 2'd1, 1'b0, 3'b000);
    trial("R7", 8'h06, 2'd1, 1'b0, 3'b000);
    trial("R7", 8'h06, 2'd1, 1'b1, 3'b000);
    trial("R7", 8'h04, 2'd2, 1'b0, 3'b000);
    trial("R7", 8'hB7, 2'd1, 1'b0, 3'b000);
    trial("R7", 8'hE9, 2'd1, 1'b1, 3'b000);
    trial("R8", 8'h02, 2'd1, 1'b0, 3'b000);
    trial("R8", 8'h02, 2'd1, 1'b1, 3'b000);
    trial("R8", 8'h77, 2'd2, 1'b0, 3'b000);
    trial("R10", 8'hC3, 2'd1, 1'b0, 3'b000);
    trial("R2", 8'h35, 2'd0, 1'b0, 3'b000);
    trial("R2", 8'h35, 2'd3, 1'b0, 3'b000);
    tbl[0][11] = 1'b0;
    trial("R3", 8'h05, 2'd1, 1'b0, 3'b000);
    set_slot(12, 1, 0, 8'hE9);
    trial("R8", 8'hE9, 2'd1, 1'b0, 3'b000);

    // R2: inactive mode leaves the block idle, then an active byte is taken
    @(negedge clk); rst_n = 1'b0; mode = 2'd0;
    @(negedge clk); rst_n = 1'b1;
    byte_in = 8'h9F; bvalid = 1'b1;
    @(negedge clk);
    check("R2", "inactive sel", 32'(dp_sel), 0);
    check("R2", "inactive ready", 32'(bready), 0);
    mode = 2'd1;
    @(negedge clk); bvalid = 1'b0;
    check("R2", "taken after activation", 32'(dp_sel), 32'h2);

    // random tables with a small opcode pool to force collisions
    void'($urandom(32'h5EED_1234));
    for (int t = 0; t < 300; t++) begin
      logic [1:0] md;
      for (int i = 0; i < NS; i++) begin
        tbl[i] = {($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0),
                  2'($urandom_range(0, 3)), 8'hA0 | 8'($urandom_range(0, 15))};
      end
      md = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3)) : 2'($urandom_range(1, 2));
      trial("R3", 8'hA0 | 8'($urandom_range(0, 15)), md, 1'($urandom_range(0, 1)),
            3'($urandom_range(0, 7)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule